// File: doc/BRIEF.md
# Window Line Fetch Request Generator

This block turns the configuration of one overlay window into a stream of word-aligned memory read requests, one line at a time. A frame-start pulse from the display timing logic rewinds the line counter. Each later line-start pulse, while the window is enabled, makes the block work out the byte address of the first pixel to be read on the next buffer row. It then issues that row's words as bursts on a valid/acknowledge request port.

The address arithmetic uses the padded row width of the buffer in pixels, the source offsets and the bytes per pixel taken from a format code. The burst size comes from the padded row width alone, and does not follow the window width. The block fetches at most as many lines per frame as the window height allows. Returned pixel data, unpacking and blending are handled elsewhere.

Top module: `win_fetch_gen`

## Requirements
- R1: After reset no request is pending (`reqValid` low) and the line counter is zero, so the first fetched line reads buffer row `offsetY`.
- R2: `pixFmt` code 0 (16-bit 5-6-5) means 2 bytes per pixel, and codes 1 to 8 (all 32-bit layouts, with or without alpha) mean 4 bytes per pixel. The byte address of the first pixel of line n is `baseAddr + ((offsetY + n) * wholeWidth + offsetX) * bytesPerPixel`.
- R3: The first request of a line appears on the cycle after the accepted line-start pulse. Every `reqAddr` is a byte address with bits [1:0] zero, and the first one equals the line's first-pixel address rounded down to a 4-byte word.
- R4: `reqLen` gives the burst size as a plain count of 4-byte words. The full burst is 8 words when `wholeWidth` is below 128 and 16 words otherwise, whatever the window width.
- R5: A line moves `ceil((firstPixelAddr mod 4 + winWidth * bytesPerPixel) / 4)` words. Its bursts follow on from each other in address order, all of them full except the last, which carries only the words left. No request goes past the end of the line.
- R6: A pending request keeps its address and length unchanged until `reqAck` is seen high.
- R7: A line-start pulse while `winEnable` is low starts nothing and does not advance the line counter.
- R8: A line-start pulse while a line is still being requested is ignored.
- R9: After `winHeight` lines in a frame, further line-start pulses issue no request until the next frame start.
- R10: A frame-start pulse drops any pending request on the next cycle, abandons the rest of that line and rewinds the line counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse at the start of each frame |
| lineStart | input | 1 | One-cycle pulse at the start of each output line |
| winEnable | input | 1 | Window enable |
| baseAddr | input | ADDR_W | Byte address of buffer pixel (0,0) |
| wholeWidth | input | DIM_W | Padded buffer row width in pixels |
| offsetX | input | DIM_W | Source column of the first pixel read |
| offsetY | input | DIM_W | Source row of the first line read |
| winWidth | input | DIM_W | Pixels read per line (at least 1) |
| winHeight | input | DIM_W | Lines fetched per frame |
| pixFmt | input | FMT_W | Pixel format code |
| reqValid | output | 1 | Read request pending |
| reqAddr | output | ADDR_W | Word-aligned byte address of the burst |
| reqLen | output | LEN_W | Burst length in 4-byte words |
| reqAck | input | 1 | Request accepted when high with `reqValid` |

## Verification
The properties take the configuration inputs to be steady from a line-start pulse until that line's last acknowledge. They also take `winWidth` to be at least one pixel, and `frameStart` never to share a cycle with an acknowledge. The bench changes the configuration only while no line is in flight and raises the acknowledge only on cycles where it has seen a request. It aborts a line with a frame-start pulse only on a cycle where it holds the acknowledge low.

// File: rtl/wfetch_pkg.sv
package wfetch_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_BURST
  } fetchState_t;

  // strobes from the sequencer to the address datapath
  typedef struct packed {
    logic clearFrame;  // rewind the line counter
    logic loadLine;    // compute and capture a new line
    logic advance;     // current burst accepted
    logic lineDone;    // the accepted burst was the last of the line
  } fetchStrobe_t;

  // format code 0 is the only 2-byte layout; everything else is 4 bytes
  function automatic logic isFourByte(input logic [3:0] fmt);
    return fmt != 4'd0;
  endfunction

endpackage

// File: rtl/wfetch_ctrl.sv
module wfetch_ctrl
  import wfetch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         lineStart,
  input  logic         winEnable,
  input  logic         reqAck,
  input  logic         lastBurst,
  input  logic         linesExhausted,
  output fetchStrobe_t strobe,
  output logic         reqValid
);

  fetchState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (frameStart) begin
      strobe.clearFrame = 1'b1;
      stateNext         = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (lineStart && winEnable && !linesExhausted) begin
            strobe.loadLine = 1'b1;
            stateNext       = ST_BURST;
          end
        end
        ST_BURST: begin
          if (reqAck) begin
            strobe.advance = 1'b1;
            if (lastBurst) begin
              strobe.lineDone = 1'b1;
              stateNext       = ST_IDLE;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqValid = (state == ST_BURST);

endmodule

// File: rtl/wfetch_dp.sv
module wfetch_dp
  import wfetch_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DIM_W        = 12,
  parameter int FMT_W        = 4,
  parameter int WIDE_BURST   = 16,
  parameter int NARROW_BURST = 8,
  parameter int NARROW_LIMIT = 128,
  parameter int LEN_W        = $clog2(WIDE_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DIM_W-1:0]  wholeWidth,
  input  logic [DIM_W-1:0]  offsetX,
  input  logic [DIM_W-1:0]  offsetY,
  input  logic [DIM_W-1:0]  winWidth,
  input  logic [DIM_W-1:0]  winHeight,
  input  logic [FMT_W-1:0]  pixFmt,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              lastBurst,
  output logic              linesExhausted
);

  localparam int ROW_W    = DIM_W + 1;
  localparam int PIX_W    = 2 * DIM_W + 2;
  localparam int BYTE_W   = PIX_W + 2;
  localparam int LBYTES_W = DIM_W + 2;
  localparam int WORDS_W  = DIM_W + 1;

  logic [DIM_W-1:0]   lineCount;
  logic [ADDR_W-1:0]  curAddr;
  logic [WORDS_W-1:0] wordsLeft;
  logic [LEN_W-1:0]   burstLen;

  logic               fourByte;
  logic [ROW_W-1:0]   rowIdx;
  logic [PIX_W-1:0]   pixIdx;
  logic [BYTE_W-1:0]  byteOff;
  logic [ADDR_W-1:0]  lineAddr;
  logic [LBYTES_W-1:0] lineBytes;
  logic [LBYTES_W:0]  spanBytes;
  logic [WORDS_W-1:0] lineWords;
  logic [LEN_W-1:0]   pickedBurst;

  assign fourByte = isFourByte(4'(pixFmt));
  assign rowIdx   = ROW_W'(offsetY) + ROW_W'(lineCount);
  assign pixIdx   = PIX_W'(rowIdx) * PIX_W'(wholeWidth) + PIX_W'(offsetX);
  assign byteOff  = fourByte ? {pixIdx, 2'b00} : {1'b0, pixIdx, 1'b0};
  assign lineAddr = baseAddr + ADDR_W'(byteOff);

  assign lineBytes = fourByte ? {winWidth, 2'b00} : {1'b0, winWidth, 1'b0};
  assign spanBytes = (LBYTES_W + 1)'(lineAddr[1:0]) + (LBYTES_W + 1)'(lineBytes)
                   + (LBYTES_W + 1)'(3);
  assign lineWords = spanBytes[LBYTES_W:2];

  // burst size depends only on the padded row width
  generate
    if (NARROW_LIMIT > 0) begin : g_narrowSel
      assign pickedBurst = (int'(wholeWidth) < NARROW_LIMIT) ? LEN_W'(NARROW_BURST)
                                                             : LEN_W'(WIDE_BURST);
    end else begin : g_wideOnly
      assign pickedBurst = LEN_W'(WIDE_BURST);
    end
  endgenerate

  assign lastBurst      = wordsLeft <= WORDS_W'(burstLen);
  assign reqLen         = lastBurst ? LEN_W'(wordsLeft) : burstLen;
  assign reqAddr        = curAddr;
  assign linesExhausted = lineCount >= winHeight;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      wordsLeft <= '0;
      burstLen  <= '0;
    end else if (strobe.loadLine) begin
      curAddr   <= {lineAddr[ADDR_W-1:2], 2'b00};
      wordsLeft <= lineWords;
      burstLen  <= pickedBurst;
    end else if (strobe.advance) begin
      curAddr   <= curAddr + ADDR_W'({reqLen, 2'b00});
      wordsLeft <= wordsLeft - WORDS_W'(reqLen);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearFrame) lineCount <= '0;
    else if (strobe.lineDone)       lineCount <= lineCount + 1'b1;
  end

endmodule

// File: rtl/win_fetch_gen.sv
module win_fetch_gen
  import wfetch_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DIM_W        = 12,
  parameter int FMT_W        = 4,
  parameter int WIDE_BURST   = 16,
  parameter int NARROW_BURST = 8,
  parameter int NARROW_LIMIT = 128,
  parameter int LEN_W        = $clog2(WIDE_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              winEnable,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DIM_W-1:0]  wholeWidth,
  input  logic [DIM_W-1:0]  offsetX,
  input  logic [DIM_W-1:0]  offsetY,
  input  logic [DIM_W-1:0]  winWidth,
  input  logic [DIM_W-1:0]  winHeight,
  input  logic [FMT_W-1:0]  pixFmt,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  input  logic              reqAck
);

  fetchStrobe_t strobe;
  logic         lastBurst;
  logic         linesExhausted;

  wfetch_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .frameStart     (frameStart),
    .lineStart      (lineStart),
    .winEnable      (winEnable),
    .reqAck         (reqAck),
    .lastBurst      (lastBurst),
    .linesExhausted (linesExhausted),
    .strobe         (strobe),
    .reqValid       (reqValid)
  );

  wfetch_dp #(
    .ADDR_W       (ADDR_W),
    .DIM_W        (DIM_W),
    .FMT_W        (FMT_W),
    .WIDE_BURST   (WIDE_BURST),
    .NARROW_BURST (NARROW_BURST),
    .NARROW_LIMIT (NARROW_LIMIT),
    .LEN_W        (LEN_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .baseAddr       (baseAddr),
    .wholeWidth     (wholeWidth),
    .offsetX        (offsetX),
    .offsetY        (offsetY),
    .winWidth       (winWidth),
    .winHeight      (winHeight),
    .pixFmt         (pixFmt),
    .reqAddr        (reqAddr),
    .reqLen         (reqLen),
    .lastBurst      (lastBurst),
    .linesExhausted (linesExhausted)
  );

endmodule

// File: rtl/win_fetch_gen_chk.sv
module win_fetch_gen_chk #(
  parameter int ADDR_W       = 32,
  parameter int DIM_W        = 12,
  parameter int WIDE_BURST   = 16,
  parameter int NARROW_BURST = 8,
  parameter int NARROW_LIMIT = 128,
  parameter int LEN_W        = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              lineStart,
  input logic              winEnable,
  input logic [DIM_W-1:0]  wholeWidth,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [LEN_W-1:0]  reqLen,
  input logic              reqAck
);

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr[1:0] == 2'b00));

  p_len_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != '0) &&
      (int'(reqLen) <= ((int'(wholeWidth) < NARROW_LIMIT) ? NARROW_BURST : WIDE_BURST)));

  p_contig_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck && !frameStart) |=>
      (!reqValid || (reqAddr == $past(reqAddr) + ADDR_W'({$past(reqLen), 2'b00}))));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck && !frameStart) |=>
      (reqValid && $stable(reqAddr) && $stable(reqLen)));

  p_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(lineStart && winEnable));

  p_frame_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !reqValid);

endmodule

bind win_fetch_gen win_fetch_gen_chk #(
  .ADDR_W       (ADDR_W),
  .DIM_W        (DIM_W),
  .WIDE_BURST   (WIDE_BURST),
  .NARROW_BURST (NARROW_BURST),
  .NARROW_LIMIT (NARROW_LIMIT),
  .LEN_W        (LEN_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .lineStart  (lineStart),
  .winEnable  (winEnable),
  .wholeWidth (wholeWidth),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqLen     (reqLen),
  .reqAck     (reqAck)
);

// File: tb/win_fetch_gen_tb.sv
module win_fetch_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic        winEnable = 1'b1;
  logic [31:0] baseAddr = '0;
  logic [11:0] wholeWidth = 12'd100;
  logic [11:0] offsetX = '0;
  logic [11:0] offsetY = '0;
  logic [11:0] winWidth = 12'd1;
  logic [11:0] winHeight = 12'd4;
  logic [3:0]  pixFmt = '0;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic [4:0]  reqLen;
  logic        reqAck = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  win_fetch_gen u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .winEnable(winEnable), .baseAddr(baseAddr), .wholeWidth(wholeWidth),
    .offsetX(offsetX), .offsetY(offsetY), .winWidth(winWidth),
    .winHeight(winHeight), .pixFmt(pixFmt), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqAck(reqAck)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [3:0]  fmt;
    logic [11:0] whole;
    logic [11:0] offX;
    logic [11:0] offY;
    logic [11:0] width;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000_0000, 4'd0, 12'd100, 12'd3,  12'd2, 12'd37},
    '{32'h2000_0000, 4'd1, 12'd128, 12'd0,  12'd0, 12'd40},
    '{32'h3000_0040, 4'd8, 12'd640, 12'd10, 12'd5, 12'd20},
    '{32'h4000_0000, 4'd0, 12'd127, 12'd0,  12'd1, 12'd128},
    '{32'h5000_0000, 4'd5, 12'd127, 12'd7,  12'd0, 12'd5},
    '{32'h6000_0000, 4'd0, 12'd200, 12'd1,  12'd0, 12'd1}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int bpp();
    return (pixFmt == 4'd0) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expLineAddr(input int line);
    return baseAddr + 32'((int'(offsetY) + line) * int'(wholeWidth) + int'(offsetX)) * 32'(bpp());
  endfunction

  function automatic int expWords(input logic [31:0] la);
    return (int'(la[1:0]) + int'(winWidth) * bpp() + 3) / 4;
  endfunction

  function automatic int expBurst();
    return (int'(wholeWidth) < 128) ? 8 : 16;
  endfunction

  task automatic pulseFrame();
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
  endtask

  // fetch one line, checking every burst; optionally hold the first one
  task automatic runLine(input int line, input int hold, input bit stray);
    logic [31:0] la;
    logic [31:0] a;
    int left;
    int len;
    la   = expLineAddr(line);
    a    = la & ~32'd3;
    left = expWords(la);
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    for (int b = 0; left > 0 && b < 600; b++) begin
      len = (left < expBurst()) ? left : expBurst();
      check(reqValid === 1'b1, "R3 request pending", longint'(reqValid), 1);
      check(reqAddr === a, "R2 R3 R5 burst address", longint'(reqAddr), longint'(a));
      check(int'(reqLen) == len, "R4 R5 burst length", longint'(reqLen), longint'(len));
      if (b == 0) begin
        for (int h = 0; h < hold; h++) begin
          lineStart = stray;
          @(negedge clk) lineStart = 1'b0;
          check(reqValid === 1'b1 && reqAddr === a && int'(reqLen) == len,
                "R6 held request", longint'(reqAddr), longint'(a));
        end
      end
      reqAck = 1'b1;
      @(negedge clk) reqAck = 1'b0;
      left -= len;
      a    += 32'(len * 4);
    end
    check(reqValid === 1'b0, "R5 line ends after last burst", longint'(reqValid), 0);
  endtask

  task automatic applyVec(input vec_t v);
    baseAddr = v.base; pixFmt = v.fmt; wholeWidth = v.whole;
    offsetX = v.offX; offsetY = v.offY; winWidth = v.width;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqValid === 1'b0, "R1 idle in reset", longint'(reqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqValid === 1'b0, "R1 idle after reset", longint'(reqValid), 0);

    // R1: first line after reset reads row offsetY without a frame pulse
    applyVec(VECS[0]);
    runLine(0, 0, 1'b0);

    // table walk: R2 R3 R4 R5 over formats, widths and offsets
    for (int i = 0; i < NVEC; i++) begin
      applyVec(VECS[i]);
      pulseFrame();
      runLine(0, 0, 1'b0);
    end

    // R6 and R8: hold the first burst, pulse a stray line start meanwhile
    applyVec(VECS[1]);
    pulseFrame();
    runLine(0, 3, 1'b1);
    @(negedge clk);
    check(reqValid === 1'b0, "R8 stray line start ignored", longint'(reqValid), 0);
    runLine(1, 0, 1'b0);

    // R7: disabled window ignores line start and keeps its count
    pulseFrame();
    winEnable = 1'b0;
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(reqValid === 1'b0, "R7 disabled window", longint'(reqValid), 0);
      @(negedge clk);
    end
    winEnable = 1'b1;
    runLine(0, 0, 1'b0);

    // R9: height limit
    applyVec(VECS[2]);
    winHeight = 12'd2;
    pulseFrame();
    runLine(0, 0, 1'b0);
    runLine(1, 0, 1'b0);
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    check(reqValid === 1'b0, "R9 no line past height", longint'(reqValid), 0);
    @(negedge clk);
    check(reqValid === 1'b0, "R9 still idle", longint'(reqValid), 0);
    pulseFrame();
    runLine(0, 0, 1'b0);

    // R10: frame start abandons a line and rewinds the count
    winHeight = 12'd4;
    applyVec(VECS[1]);
    pulseFrame();
    runLine(0, 0, 1'b0);
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    reqAck = 1'b1;
    @(negedge clk) reqAck = 1'b0;
    check(reqValid === 1'b1, "R10 second burst pending", longint'(reqValid), 1);
    frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    check(reqValid === 1'b0, "R10 request dropped", longint'(reqValid), 0);
    runLine(0, 0, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule